// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps the 8-bit status byte of a small 8-bit processor core. Three arithmetic flags (zero, digit carry, carry) are loaded from the ALU one at a time, each through its own enable. Two reset-cause bits (time-out and power-down) follow system events only: power-up, a watchdog-clear instruction, sleep entry and watchdog expiry.

An instruction may also name the status byte as its destination. In that case the block decides, bit by bit, whether the written data or the ALU result lands in each flag. The two reset-cause bits never take written data. The read value always shows zero in the three bits above the reset-cause bits. The core drives the enables and event strobes for one clock per instruction, and the new value can be read after the next rising edge.

Top module: `status_reg_unit`

## Requirements
- R1: Bits 7, 6 and 5 of `status_q` always read 0.
- R2: After reset `status_q` is 0x18: time-out (bit 4) and power-down (bit 3) are 1, and zero (bit 2), digit carry (bit 1) and carry (bit 0) are 0.
- R3: A write (`wr_en`=1) with none of `z_upd`, `dc_upd` or `c_upd` set loads `wr_data[2:0]` into bits 2:0 on the next edge. Bit set, bit clear, nibble swap and move instructions use this path.
- R4: A write with at least one flag enable set discards `wr_data[2:0]` entirely. Each enabled flag takes its ALU value and each flag that is not enabled keeps its value. A clear of the status byte (data 0, only `z_upd` with `z_val`=1) therefore gives 000uu1uu.
- R5: With no write, a flag whose enable is set takes its ALU value on the next edge, and a flag whose enable is clear holds.
- R6: Bits 4 and 3 ignore `wr_data`; without events they hold across writes.
- R7: `pwr_up` sets both time-out and power-down, overriding every other event.
- R8: `wdt_clear` alone sets both time-out and power-down.
- R9: `sleep_enter` sets time-out and clears power-down. When it coincides with `wdt_clear`, power-down is still cleared.
- R10: `wdt_expire` clears time-out and wins over `wdt_clear` and `sleep_enter` for that bit. It leaves power-down to the other events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Instruction writes the status byte this cycle |
| wr_data | input | 8 | Data written by that instruction |
| z_upd | input | 1 | ALU updates the zero flag |
| z_val | input | 1 | New zero flag value |
| dc_upd | input | 1 | ALU updates the digit-carry flag |
| dc_val | input | 1 | New digit-carry value (carry out of bit 3; active-low borrow on subtract) |
| c_upd | input | 1 | ALU updates the carry flag |
| c_val | input | 1 | New carry value (carry out of the top bit, borrow inverted, or rotated-out bit) |
| pwr_up | input | 1 | Power-up event strobe |
| wdt_clear | input | 1 | Watchdog-clear instruction strobe |
| sleep_enter | input | 1 | Sleep instruction strobe |
| wdt_expire | input | 1 | Watchdog time-out strobe |
| status_q | output | 8 | Status byte read value |

## Verification
Directed sequences first set each flag through a plain write. They then repeat the write with one, two and three flag enables set, which tells the write-discard rule apart from a per-flag merge. The clear pattern (data 0 with only the zero enable) checks that the unchanged digit carry and carry really hold. Event strobes are driven alone and in every pairing of clear, sleep and expiry, which separates the priority chosen for time-out from the one chosen for power-down. A long run of random writes, enables and sparse events is then compared each cycle against a behavioural model.

// File: rtl/sru_pkg.sv
package sru_pkg;
  // Bit positions are behaviour: the core decodes them when reading the byte.
  localparam int BIT_C  = 0;
  localparam int BIT_DC = 1;
  localparam int BIT_Z  = 2;
  localparam int BIT_PD = 3;
  localparam int BIT_TO = 4;
  localparam int NUM_FLAGS   = 3;
  localparam int USED_BITS   = 5;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic to;
    logic pd;
  } cause_bits_t;

  localparam cause_bits_t CAUSE_RESET = '{to: 1'b1, pd: 1'b1};
  localparam logic [NUM_FLAGS-1:0] FLAGS_RESET = '0;
endpackage

// File: rtl/sru_rst_sync.sv
module sru_rst_sync #(
  parameter int STAGES = sru_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sru_flag_slice.sv
module sru_flag_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_val,
  input  logic wr_take,
  input  logic wr_bit,
  input  logic upd,
  input  logic upd_val,
  output logic flag_q
);
  logic flag_d;
  logic flag_en;

  // ALU result beats written data; otherwise hold.
  always_comb begin
    flag_en = upd | wr_take;
    if (upd) flag_d = upd_val;
    else     flag_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= rst_val;
    else if (flag_en) flag_q <= flag_d;
  end
endmodule

// File: rtl/sru_cause_bits.sv
module sru_cause_bits
  import sru_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwr_up,
  input  logic        wdt_clear,
  input  logic        sleep_enter,
  input  logic        wdt_expire,
  output cause_bits_t cause_q
);
  cause_bits_t cause_d;
  logic        cause_en;

  always_comb begin
    cause_en = pwr_up | wdt_clear | sleep_enter | wdt_expire;
    cause_d  = cause_q;
    // time-out: power-up > expiry > clear/sleep
    if (pwr_up)                      cause_d.to = 1'b1;
    else if (wdt_expire)             cause_d.to = 1'b0;
    else if (wdt_clear | sleep_enter) cause_d.to = 1'b1;
    // power-down: power-up > sleep > clear
    if (pwr_up)           cause_d.pd = 1'b1;
    else if (sleep_enter) cause_d.pd = 1'b0;
    else if (wdt_clear)   cause_d.pd = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cause_q <= CAUSE_RESET;
    else if (cause_en) cause_q <= cause_d;
  end
endmodule

// File: rtl/status_reg_unit.sv
module status_reg_unit
  import sru_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             z_upd,
  input  logic             z_val,
  input  logic             dc_upd,
  input  logic             dc_val,
  input  logic             c_upd,
  input  logic             c_val,
  input  logic             pwr_up,
  input  logic             wdt_clear,
  input  logic             sleep_enter,
  input  logic             wdt_expire,
  output logic [REG_W-1:0] status_q
);
  localparam int PAD_W = REG_W - USED_BITS;

  logic                 rst_sync_n;
  logic [NUM_FLAGS-1:0] upd_vec;
  logic [NUM_FLAGS-1:0] val_vec;
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 wr_take;
  cause_bits_t          cause_q;

  sru_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    upd_vec           = '0;
    val_vec           = '0;
    upd_vec[BIT_C]    = c_upd;
    upd_vec[BIT_DC]   = dc_upd;
    upd_vec[BIT_Z]    = z_upd;
    val_vec[BIT_C]    = c_val;
    val_vec[BIT_DC]   = dc_val;
    val_vec[BIT_Z]    = z_val;
    // Any flag-affecting instruction disables the write to all three flags.
    wr_take           = wr_en & ~(|upd_vec);
  end

  for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
    sru_flag_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rst_val (FLAGS_RESET[gi]),
      .wr_take (wr_take),
      .wr_bit  (wr_data[gi]),
      .upd     (upd_vec[gi]),
      .upd_val (val_vec[gi]),
      .flag_q  (flags_q[gi])
    );
  end

  sru_cause_bits u_cause (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pwr_up      (pwr_up),
    .wdt_clear   (wdt_clear),
    .sleep_enter (sleep_enter),
    .wdt_expire  (wdt_expire),
    .cause_q     (cause_q)
  );

  if (PAD_W > 0) begin : g_pad
    assign status_q = {{PAD_W{1'b0}}, cause_q.to, cause_q.pd, flags_q};
  end else begin : g_nopad
    assign status_q = {cause_q.to, cause_q.pd, flags_q};
  end
endmodule

// File: rtl/sru_checker.sv
module sru_checker
  import sru_pkg::*;
#(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             z_upd,
  input logic             z_val,
  input logic             dc_upd,
  input logic             c_upd,
  input logic             pwr_up,
  input logic             wdt_clear,
  input logic             sleep_enter,
  input logic             wdt_expire,
  input logic [REG_W-1:0] status_q
);
  logic any_evt;
  assign any_evt = pwr_up | wdt_clear | sleep_enter | wdt_expire;

  assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[REG_W-1:USED_BITS] == '0);

  assert_write_skip_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (z_upd || dc_upd) && !c_upd) |=> $stable(status_q[BIT_C]));

  assert_alu_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    z_upd |=> status_q[BIT_Z] == $past(z_val));

  assert_cause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_evt) |=> $stable(status_q[BIT_TO:BIT_PD]));

  assert_powerup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_up |=> status_q[BIT_TO:BIT_PD] == 2'b11);

  assert_sleep_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_enter && !pwr_up) |=> !status_q[BIT_PD]);

  assert_expire_to_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_expire && !pwr_up) |=> !status_q[BIT_TO]);
endmodule

bind status_reg_unit sru_checker #(.REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wr_en       (wr_en),
  .z_upd       (z_upd),
  .z_val       (z_val),
  .dc_upd      (dc_upd),
  .c_upd       (c_upd),
  .pwr_up      (pwr_up),
  .wdt_clear   (wdt_clear),
  .sleep_enter (sleep_enter),
  .wdt_expire  (wdt_expire),
  .status_q    (status_q)
);

// File: tb/status_reg_unit_test.sv
module status_reg_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, z_upd, z_val, dc_upd, dc_val, c_upd, c_val;
  logic       pwr_up, wdt_clear, sleep_enter, wdt_expire;
  logic [7:0] wr_data;
  logic [7:0] status_q;

  int checks   = 0;
  int failures = 0;
  int ref_to, ref_pd, ref_z, ref_dc, ref_c;
  bit done = 0;

  always #2.5 clk = ~clk;

  status_reg_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .z_upd(z_upd), .z_val(z_val), .dc_upd(dc_upd), .dc_val(dc_val),
    .c_upd(c_upd), .c_val(c_val), .pwr_up(pwr_up), .wdt_clear(wdt_clear),
    .sleep_enter(sleep_enter), .wdt_expire(wdt_expire), .status_q(status_q)
  );

  function automatic int ref_byte();
    return ref_to * 16 + ref_pd * 8 + ref_z * 4 + ref_dc * 2 + ref_c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_data = 0; z_upd = 0; z_val = 0; dc_upd = 0; dc_val = 0;
    c_upd = 0; c_val = 0; pwr_up = 0; wdt_clear = 0; sleep_enter = 0; wdt_expire = 0;
  endtask

  // Behavioural model step from the requirements.
  task automatic model_step();
    if (wr_en && !(z_upd || dc_upd || c_upd)) begin
      ref_c = int'(wr_data[0]); ref_dc = int'(wr_data[1]); ref_z = int'(wr_data[2]);
    end
    if (z_upd)  ref_z  = int'(z_val);
    if (dc_upd) ref_dc = int'(dc_val);
    if (c_upd)  ref_c  = int'(c_val);
    if (pwr_up)                        ref_to = 1;
    else if (wdt_expire)               ref_to = 0;
    else if (wdt_clear || sleep_enter) ref_to = 1;
    if (pwr_up)           ref_pd = 1;
    else if (sleep_enter) ref_pd = 0;
    else if (wdt_clear)   ref_pd = 1;
  endtask

  // Inputs already set at a negedge; apply one edge and compare.
  task automatic step();
    string ftag, ctag;
    if (wr_en && (z_upd || dc_upd || c_upd)) ftag = "R4";
    else if (wr_en)                          ftag = "R3";
    else                                     ftag = "R5";
    if (pwr_up)           ctag = "R7";
    else if (wdt_expire)  ctag = "R10";
    else if (sleep_enter) ctag = "R9";
    else if (wdt_clear)   ctag = "R8";
    else                  ctag = "R6";
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R1", int'(status_q[7:5]), 0);
    check(ftag, int'(status_q[2:0]), ref_byte() % 8);
    check(ctag, int'(status_q[4:3]), ref_byte() / 8);
    idle();
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  initial begin
    idle();
    rst_n = 0;
    ref_to = 1; ref_pd = 1; ref_z = 0; ref_dc = 0; ref_c = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R2", int'(status_q), 8'h18);

    // R3: plain writes reach the flags; R6: cause bits ignore them
    do_write(8'hE7);
    check("R3", int'(status_q), 8'h1F);
    do_write(8'hFA);
    check("R6", int'(status_q), 8'h1A);
    do_write(8'h03);
    // R4: clear instruction -> 000uu1uu
    wr_en = 1; wr_data = 8'h00; z_upd = 1; z_val = 1; step();
    check("R4", int'(status_q), 8'h1F);
    // R4: two enables, write data ignored
    wr_en = 1; wr_data = 8'h07; dc_upd = 1; dc_val = 0; c_upd = 1; c_val = 0; step();
    check("R4", int'(status_q), 8'h1C);
    wr_en = 1; wr_data = 8'h00; z_upd = 1; z_val = 0; dc_upd = 1; dc_val = 1;
    c_upd = 1; c_val = 1; step();
    check("R4", int'(status_q), 8'h1B);
    // R5: ALU only, partial enables
    c_upd = 1; c_val = 0; step();
    check("R5", int'(status_q), 8'h1A);
    step();
    check("R5", int'(status_q), 8'h1A);

    // events
    sleep_enter = 1; step();
    check("R9", int'(status_q[4:3]), 2'b10);
    wdt_clear = 1; step();
    check("R8", int'(status_q[4:3]), 2'b11);
    wdt_expire = 1; step();
    check("R10", int'(status_q[4:3]), 2'b01);
    wdt_expire = 1; wdt_clear = 1; step();
    check("R10", int'(status_q[4:3]), 2'b01);
    wdt_expire = 1; sleep_enter = 1; step();
    check("R10", int'(status_q[4:3]), 2'b00);
    sleep_enter = 1; wdt_clear = 1; step();
    check("R9", int'(status_q[4:3]), 2'b10);
    pwr_up = 1; wdt_expire = 1; sleep_enter = 1; step();
    check("R7", int'(status_q[4:3]), 2'b11);
    wdt_expire = 1; step();
    wr_en = 1; wr_data = 8'h18; step();
    check("R6", int'(status_q[4:3]), 2'b01);

    // random run against the model
    for (int i = 0; i < 4000; i++) begin
      wr_en   = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      z_upd   = ($urandom % 3) == 0;  z_val  = 1'($urandom);
      dc_upd  = ($urandom % 3) == 0;  dc_val = 1'($urandom);
      c_upd   = ($urandom % 3) == 0;  c_val  = 1'($urandom);
      pwr_up      = ($urandom % 40) == 0;
      wdt_clear   = ($urandom % 8) == 0;
      sleep_enter = ($urandom % 8) == 0;
      wdt_expire  = ($urandom % 8) == 0;
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule